// File: doc/BRIEF.md
# Transmit DMA Channel Controller

This block is the control engine of one transmit DMA channel. It walks a ring of transmit descriptors in memory. For each descriptor it owns, it issues burst read requests that cover the descriptor's data buffer. Software controls it with a level-sensitive run bit, a list base address with a write strobe, a burst length field, a times-eight burst mode bit and a one-cycle resume strobe.

The channel has three visible states: stopped, running and suspended. When it fetches a descriptor that the DMA does not own, it suspends and raises a sticky buffer-unavailable flag. A resume strobe makes it fetch the same descriptor again. A run bit that is lowered mid-packet lets that packet drain before the channel stops. The ring position is kept across a stop and a later start, unless software loads a new list base while the channel is stopped.

Top module: `txdma_chan_ctrl`

## Requirements
- R1: After reset the state output reads 0 (stopped), `dsc_req` and `brst_req` are low and `st_tbu` is low. The state output encodes stopped as 0, running as 1 and suspended as 2.
- R2: With `cfg_run` high in the stopped state, the channel goes to running and requests the descriptor at the current position. A descriptor response with `dsc_own` low moves the channel to suspended and sets `st_tbu`. `st_tbu` stays set until the next accepted start, which clears it.
- R3: In suspended, a `cfg_resume` pulse with `cfg_run` high fetches the same descriptor address again. A list base write made in any state other than stopped is ignored.
- R4: If `cfg_run` falls while a packet's bursts are outstanding, every remaining beat of that packet is still requested. The channel then enters stopped without fetching another descriptor.
- R5: If `cfg_run` is low in suspended, the channel is stopped one cycle later. This has priority over a resume.
- R6: On stopping after a completed packet, the next descriptor address is kept and the next start fetches from it. A list base write while stopped replaces that position with the new base.
- R7: After each completed packet the position advances by `DSC_STRIDE` bytes. After `RING_LEN` descriptors it wraps back to the list base.
- R8: No burst asks for more beats than the burst length (legal values 1, 2, 4, 8, 16, 32). With `cfg_pbl_x8` set the limit is eight times that value.
- R9: Any other burst length value raises `st_pbl_err` and is used as a burst length of 1.
- R10: A buffer of L bytes needs ceil(L/`BEAT_BYTES`) beats. Each burst is clipped to the beats still left. Bursts start at the buffer address and follow each other contiguously (address advances by beats × `BEAT_BYTES`). A zero-length buffer produces no burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_run | input | 1 | Run bit: high requests running, low requests stop |
| cfg_base | input | AW | Descriptor list base address |
| cfg_base_we | input | 1 | Load strobe for `cfg_base` (acted on only when stopped) |
| cfg_pbl | input | 6 | Burst length in beats |
| cfg_pbl_x8 | input | 1 | Multiply the burst limit by eight |
| cfg_resume | input | 1 | One-cycle strobe: refetch the descriptor in suspended |
| dsc_req | output | 1 | Descriptor fetch request |
| dsc_addr | output | AW | Address of the descriptor being fetched |
| dsc_ack | input | 1 | Descriptor response valid |
| dsc_own | input | 1 | Descriptor owned by the DMA |
| dsc_buf_addr | input | AW | Buffer start address from the descriptor |
| dsc_len | input | LW | Buffer length in bytes |
| brst_req | output | 1 | Burst read request |
| brst_addr | output | AW | Burst start address |
| brst_beats | output | LW | Beats in this burst |
| brst_ack | input | 1 | Burst request accepted |
| st_state | output | 2 | 0 stopped, 1 running, 2 suspended |
| st_tbu | output | 1 | Sticky buffer-unavailable flag |
| st_pbl_err | output | 1 | Burst length value is illegal |

## Verification
The bench holds burst acceptance off and lowers the run bit mid-packet. A design that stopped at once would lose beats, and one that kept going would fetch the next descriptor. It lets the ring wrap onto a descriptor already consumed, where a wrong stride or wrap would fetch an address other than the base. It writes a base address while suspended, which a design must ignore when the following resume refetches. It also covers uneven buffer lengths, times-eight mode and illegal burst lengths, which catch clipping that overruns the buffer, a missing multiply, or an undecoded length that produces zero-beat bursts.

// File: rtl/txdma_pkg.sv
// Shared types for the transmit DMA channel controller.
package txdma_pkg;
    typedef enum logic [1:0] {
        FSM_STOP  = 2'd0,
        FSM_FETCH = 2'd1,
        FSM_BURST = 2'd2,
        FSM_SUSP  = 2'd3
    } fsm_e;

    localparam logic [1:0] STAT_STOPPED   = 2'd0;
    localparam logic [1:0] STAT_RUNNING   = 2'd1;
    localparam logic [1:0] STAT_SUSPENDED = 2'd2;
endpackage

// File: rtl/txdma_burst_calc.sv
// Burst sizing: decodes the programmed burst length, applies the x8 mode
// and clips the burst to the beats left in the buffer.
// Assumes LW >= 9 so the largest limit (256) fits the beat width.
module txdma_burst_calc #(
    parameter int LW = 16
) (
    input  logic [5:0]    pbl,
    input  logic          pbl_x8,
    input  logic [LW-1:0] rem_beats,
    output logic [LW-1:0] beats,
    output logic [8:0]    max_beats,
    output logic          pbl_err
);
    logic       legal;
    logic [5:0] pbl_eff;

    // Legal lengths are the single-bit values 1..32; anything else becomes 1.
    always_comb begin
        legal     = (pbl != 6'd0) && ((pbl & (pbl - 6'd1)) == 6'd0);
        pbl_eff   = legal ? pbl : 6'd1;
        max_beats = pbl_x8 ? {pbl_eff, 3'b000} : {3'b000, pbl_eff};
        pbl_err   = !legal;
        beats     = (rem_beats < LW'(max_beats)) ? rem_beats : LW'(max_beats);
    end
endmodule

// File: rtl/txdma_ring_ptr.sv
// Descriptor ring position: holds the list base and the index of the current
// descriptor, advances by a fixed stride and wraps after RING_LEN entries.
// Assumes RING_LEN >= 2. A base load restarts the ring at index 0.
module txdma_ring_ptr #(
    parameter int AW         = 32,
    parameter int RING_LEN   = 4,
    parameter int DSC_STRIDE = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_we,
    input  logic [AW-1:0] base_in,
    input  logic          advance,
    output logic [AW-1:0] dsc_addr
);
    localparam int IW = $clog2(RING_LEN);
    localparam logic [IW-1:0] LAST_IDX = IW'(RING_LEN - 1);

    logic [AW-1:0] base_q;
    logic [IW-1:0] idx_q;

    // Base register and ring index; base load wins over an advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            idx_q  <= '0;
        end else if (base_we) begin
            base_q <= base_in;
            idx_q  <= '0;
        end else if (advance) begin
            idx_q  <= (idx_q == LAST_IDX) ? '0 : idx_q + IW'(1);
        end
    end

    assign dsc_addr = base_q + AW'(idx_q) * AW'(DSC_STRIDE);

    // R7
    ring_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !base_we && idx_q == LAST_IDX) |=> (idx_q == '0));
endmodule

// File: rtl/txdma_chan_ctrl.sv
// Transmit DMA channel controller: stopped/running/suspended sequencing,
// descriptor fetch, and burst issue for the owned buffer.
// Assumes the descriptor and burst responders hold each response valid for
// at least the cycle in which the controller samples it.
module txdma_chan_ctrl
    import txdma_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LW         = 16,
    parameter int BEAT_BYTES = 8,
    parameter int RING_LEN   = 4,
    parameter int DSC_STRIDE = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_run,
    input  logic [AW-1:0] cfg_base,
    input  logic          cfg_base_we,
    input  logic [5:0]    cfg_pbl,
    input  logic          cfg_pbl_x8,
    input  logic          cfg_resume,
    output logic          dsc_req,
    output logic [AW-1:0] dsc_addr,
    input  logic          dsc_ack,
    input  logic          dsc_own,
    input  logic [AW-1:0] dsc_buf_addr,
    input  logic [LW-1:0] dsc_len,
    output logic          brst_req,
    output logic [AW-1:0] brst_addr,
    output logic [LW-1:0] brst_beats,
    input  logic          brst_ack,
    output logic [1:0]    st_state,
    output logic          st_tbu,
    output logic          st_pbl_err
);
    localparam int BSH = $clog2(BEAT_BYTES);

    fsm_e          state_q, state_d;
    logic [AW-1:0] buf_q;
    logic [LW-1:0] rem_q;
    logic          tbu_q;
    logic          advance;
    logic          pkt_last;
    logic [LW:0]   len_ext;
    logic [LW-1:0] beats_tot;
    logic [8:0]    max_beats;

    txdma_burst_calc #(.LW(LW)) u_calc (
        .pbl       (cfg_pbl),
        .pbl_x8    (cfg_pbl_x8),
        .rem_beats (rem_q),
        .beats     (brst_beats),
        .max_beats (max_beats),
        .pbl_err   (st_pbl_err)
    );

    txdma_ring_ptr #(.AW(AW), .RING_LEN(RING_LEN), .DSC_STRIDE(DSC_STRIDE)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .base_we  (cfg_base_we && state_q == FSM_STOP),
        .base_in  (cfg_base),
        .advance  (advance),
        .dsc_addr (dsc_addr)
    );

    // Beats needed for the buffer just fetched (rounded up).
    always_comb begin
        len_ext   = {1'b0, dsc_len} + (LW+1)'(BEAT_BYTES - 1);
        beats_tot = LW'(len_ext >> BSH);
    end

    assign pkt_last = brst_ack && (brst_beats == rem_q);

    // Next-state decision and ring advance on packet completion.
    always_comb begin
        state_d = state_q;
        advance = 1'b0;
        case (state_q)
            FSM_STOP:  if (cfg_run) state_d = FSM_FETCH;
            FSM_FETCH: if (dsc_ack) begin
                if (!dsc_own) state_d = FSM_SUSP;
                else if (beats_tot == '0) begin
                    advance = 1'b1;
                    state_d = cfg_run ? FSM_FETCH : FSM_STOP;
                end else state_d = FSM_BURST;
            end
            FSM_BURST: if (pkt_last) begin
                advance = 1'b1;
                state_d = cfg_run ? FSM_FETCH : FSM_STOP;
            end
            FSM_SUSP: begin
                if (!cfg_run) state_d = FSM_STOP;
                else if (cfg_resume) state_d = FSM_FETCH;
            end
            default: state_d = FSM_STOP;
        endcase
    end

    // State, sticky flag and buffer progress registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FSM_STOP;
            tbu_q   <= 1'b0;
            buf_q   <= '0;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == FSM_STOP && cfg_run)
                tbu_q <= 1'b0;
            else if (state_q == FSM_FETCH && dsc_ack && !dsc_own)
                tbu_q <= 1'b1;
            if (state_q == FSM_FETCH && dsc_ack && dsc_own) begin
                buf_q <= dsc_buf_addr;
                rem_q <= beats_tot;
            end else if (state_q == FSM_BURST && brst_ack) begin
                buf_q <= buf_q + (AW'(brst_beats) << BSH);
                rem_q <= rem_q - brst_beats;
            end
        end
    end

    // Port-side view of the state machine.
    always_comb begin
        dsc_req   = (state_q == FSM_FETCH);
        brst_req  = (state_q == FSM_BURST);
        brst_addr = buf_q;
        st_tbu    = tbu_q;
        case (state_q)
            FSM_STOP: st_state = STAT_STOPPED;
            FSM_SUSP: st_state = STAT_SUSPENDED;
            default:  st_state = STAT_RUNNING;
        endcase
    end

    // R8
    burst_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brst_req |-> (brst_beats != '0) && (brst_beats <= LW'(max_beats)));
    // R10
    burst_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brst_req |-> (brst_beats <= rem_q));
    // R2
    unowned_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FSM_FETCH && dsc_ack && !dsc_own) |=> (state_q == FSM_SUSP && tbu_q));
    // R2
    tbu_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tbu_q && state_q != FSM_STOP) |=> tbu_q);
    // R5
    susp_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FSM_SUSP && !cfg_run) |=> (state_q == FSM_STOP));
    // R4
    drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FSM_BURST && !pkt_last) |=> (state_q == FSM_BURST));
    // R1
    req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dsc_req && brst_req));
endmodule

// File: tb/txdma_chan_ctrl_bench.sv
module txdma_chan_ctrl_bench;
    localparam int CLK_NS = 10;
    localparam int AW = 32;
    localparam int LW = 16;

    typedef struct packed {
        logic [5:0]  pbl;
        logic        x8;
        logic [15:0] len;
        logic [7:0]  nb;
        logic [8:0]  first;
        logic [8:0]  last;
        logic        err;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{6'd8,  1'b0, 16'd64,   8'd1, 9'd8,   9'd8,   1'b0},
        '{6'd4,  1'b0, 16'd80,   8'd3, 9'd4,   9'd2,   1'b0},
        '{6'd1,  1'b0, 16'd20,   8'd3, 9'd1,   9'd1,   1'b0},
        '{6'd2,  1'b1, 16'd200,  8'd2, 9'd16,  9'd9,   1'b0},
        '{6'd3,  1'b0, 16'd16,   8'd2, 9'd1,   9'd1,   1'b1},
        '{6'd32, 1'b0, 16'd256,  8'd1, 9'd32,  9'd32,  1'b0},
        '{6'd32, 1'b1, 16'd2400, 8'd2, 9'd256, 9'd44,  1'b0},
        '{6'd0,  1'b0, 16'd8,    8'd1, 9'd1,   9'd1,   1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_run = 1'b0, cfg_base_we = 1'b0, cfg_pbl_x8 = 1'b0, cfg_resume = 1'b0;
    logic [AW-1:0] cfg_base = '0;
    logic [5:0] cfg_pbl = 6'd1;
    logic dsc_req, brst_req, st_tbu, st_pbl_err;
    logic [AW-1:0] dsc_addr, brst_addr;
    logic [LW-1:0] brst_beats;
    logic [1:0] st_state;
    logic dsc_ack = 1'b0, dsc_own = 1'b0, brst_ack = 1'b0;
    logic [AW-1:0] dsc_buf_addr = '0;
    logic [LW-1:0] dsc_len = '0;

    logic          m_own [16];
    logic [AW-1:0] m_buf [16];
    logic [LW-1:0] m_len [16];
    logic          used  [16];
    logic          hold = 1'b0;
    logic          clr = 1'b0;
    logic [AW-1:0] fetch_log [64];
    logic [AW-1:0] baddr_log [64];
    int            bbeat_log [64];
    int fetch_n = 0, burst_n = 0, beat_sum = 0;
    int n_chk = 0, n_fail = 0;

    always #(CLK_NS/2) clk = ~clk;

    txdma_chan_ctrl u_txdma_chan_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_run(cfg_run), .cfg_base(cfg_base),
        .cfg_base_we(cfg_base_we), .cfg_pbl(cfg_pbl), .cfg_pbl_x8(cfg_pbl_x8),
        .cfg_resume(cfg_resume), .dsc_req(dsc_req), .dsc_addr(dsc_addr),
        .dsc_ack(dsc_ack), .dsc_own(dsc_own), .dsc_buf_addr(dsc_buf_addr),
        .dsc_len(dsc_len), .brst_req(brst_req), .brst_addr(brst_addr),
        .brst_beats(brst_beats), .brst_ack(brst_ack), .st_state(st_state),
        .st_tbu(st_tbu), .st_pbl_err(st_pbl_err)
    );

    // Memory-side responders, driven away from the active edge.
    always @(negedge clk) begin
        dsc_ack      <= dsc_req;
        dsc_own      <= m_own[dsc_addr[7:4]] && !used[dsc_addr[7:4]];
        dsc_buf_addr <= m_buf[dsc_addr[7:4]];
        dsc_len      <= m_len[dsc_addr[7:4]];
        brst_ack     <= brst_req && !hold;
    end

    // Transaction logger; an owned descriptor is consumed once fetched.
    always @(posedge clk) begin
        if (clr) begin
            fetch_n = 0; burst_n = 0; beat_sum = 0;
            for (int i = 0; i < 16; i++) used[i] = 1'b0;
        end else begin
            if (dsc_req && dsc_ack) begin
                if (fetch_n < 64) fetch_log[fetch_n] = dsc_addr;
                if (dsc_own) used[dsc_addr[7:4]] = 1'b1;
                fetch_n++;
            end
            if (brst_req && brst_ack) begin
                if (burst_n < 64) begin
                    baddr_log[burst_n] = brst_addr;
                    bbeat_log[burst_n] = int'(brst_beats);
                end
                beat_sum += int'(brst_beats);
                burst_n++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_logs();
        clr = 1'b1; cyc(1); clr = 1'b0;
    endtask

    task automatic load_base(input logic [AW-1:0] b);
        cfg_base = b; cfg_base_we = 1'b1; cyc(1); cfg_base_we = 1'b0;
    endtask

    task automatic wait_state(input logic [1:0] s, input string req);
        int t = 0;
        while (st_state != s && t < 2000) begin cyc(1); t++; end
        check(st_state == s, req, "state reached", st_state, s);
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_own[i] = 1'b0; m_buf[i] = '0; m_len[i] = '0; used[i] = 1'b0;
        end
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        check(st_state == 2'd0, "R1", "state after reset", st_state, 0);
        check(!dsc_req && !brst_req, "R1", "requests idle", {dsc_req, brst_req}, 0);
        check(!st_tbu, "R1", "tbu after reset", st_tbu, 0);

        // Vector table: one packet per entry, then a suspend on the next slot.
        for (int v = 0; v < NV; v++) begin
            int tot;
            logic [AW-1:0] b0;
            cfg_run = 1'b0; cyc(2);
            cfg_pbl = VECS[v].pbl; cfg_pbl_x8 = VECS[v].x8;
            b0 = 32'h1000_0000 + AW'(v) * 32'h1_0000;
            m_own[0] = 1'b1; m_buf[0] = b0; m_len[0] = VECS[v].len;
            m_own[1] = 1'b0;
            clear_logs();
            load_base(32'h100);
            cfg_run = 1'b1;
            wait_state(2'd2, "R2");
            tot = (int'(VECS[v].len) + 7) / 8;
            check(st_pbl_err == VECS[v].err, "R9", "pbl error flag", st_pbl_err, VECS[v].err);
            check(burst_n == int'(VECS[v].nb), "R8 R9", "burst count", burst_n, VECS[v].nb);
            check(bbeat_log[0] == int'(VECS[v].first), "R8", "first burst beats", bbeat_log[0], VECS[v].first);
            check(bbeat_log[burst_n-1] == int'(VECS[v].last), "R10", "last burst beats",
                  bbeat_log[burst_n-1], VECS[v].last);
            check(beat_sum == tot, "R10", "total beats", beat_sum, tot);
            check(baddr_log[0] == b0, "R10", "first burst address", baddr_log[0], b0);
            check(baddr_log[burst_n-1] == b0 + AW'((tot - int'(VECS[v].last)) * 8), "R10",
                  "last burst address", baddr_log[burst_n-1],
                  b0 + AW'((tot - int'(VECS[v].last)) * 8));
            check(fetch_n == 2 && fetch_log[1] == 32'h110, "R7", "second fetch address",
                  fetch_log[1], 32'h110);
        end

        // R7 ring wrap onto an already consumed slot
        cfg_run = 1'b0; cyc(2);
        cfg_pbl = 6'd8; cfg_pbl_x8 = 1'b0;
        for (int i = 0; i < 4; i++) begin
            m_own[i] = 1'b1; m_buf[i] = 32'h2000_0000; m_len[i] = 16'd8;
        end
        m_len[2] = 16'd0;
        clear_logs();
        load_base(32'h200);
        cfg_run = 1'b1;
        wait_state(2'd2, "R7");
        check(fetch_n == 5, "R7", "fetches until wrap", fetch_n, 5);
        check(fetch_log[3] == 32'h230, "R7", "fourth descriptor address", fetch_log[3], 32'h230);
        check(fetch_log[4] == 32'h200, "R7", "wrapped address", fetch_log[4], 32'h200);
        check(beat_sum == 3, "R10", "zero-length slot gives no burst", beat_sum, 3);
        check(st_tbu, "R2", "tbu set on unowned", st_tbu, 1);

        // R3 base write ignored while suspended, resume refetches same slot
        load_base(32'h300);
        cfg_resume = 1'b1; cyc(1); cfg_resume = 1'b0;
        wait_state(2'd2, "R3");
        cyc(2);
        check(fetch_n == 6, "R3", "refetch count", fetch_n, 6);
        check(fetch_log[5] == 32'h200, "R3", "refetch address", fetch_log[5], 32'h200);
        check(st_tbu, "R2", "tbu sticky", st_tbu, 1);

        // R5 stop from suspended is immediate
        cfg_run = 1'b0; cfg_resume = 1'b1; cyc(1); cfg_resume = 1'b0;
        check(st_state == 2'd0, "R5", "stopped one cycle later", st_state, 0);

        // R2 tbu cleared by accepted start
        cfg_run = 1'b1; cyc(1);
        check(!st_tbu && st_state == 2'd1, "R2", "tbu cleared on start", st_tbu, 0);
        wait_state(2'd2, "R2");
        check(fetch_log[6] == 32'h200, "R6", "position kept across stop", fetch_log[6], 32'h200);

        // R4 stop during packet drains it; R6 resumes at next slot
        cfg_run = 1'b0; cyc(2);
        cfg_pbl = 6'd1;
        m_own[0] = 1'b1; m_len[0] = 16'd80; m_buf[0] = 32'h3000_0000;
        m_own[1] = 1'b1; m_len[1] = 16'd8;
        m_own[2] = 1'b0;
        clear_logs();
        load_base(32'h100);
        hold = 1'b1;
        cfg_run = 1'b1;
        wait_state(2'd1, "R4");
        cyc(4);
        cfg_run = 1'b0;
        cyc(3);
        check(st_state == 2'd1 && brst_req, "R4", "still draining", st_state, 1);
        hold = 1'b0;
        wait_state(2'd0, "R4");
        check(beat_sum == 10, "R4", "all beats requested", beat_sum, 10);
        check(fetch_n == 1, "R4", "no fetch after stop", fetch_n, 1);
        cfg_run = 1'b1;
        wait_state(2'd2, "R6");
        check(fetch_log[1] == 32'h110, "R6", "restart at next slot", fetch_log[1], 32'h110);
        cfg_run = 1'b0; cyc(2);
        load_base(32'h400);
        cfg_run = 1'b1;
        wait_state(2'd2, "R6");
        check(fetch_log[3] == 32'h400, "R6", "new base replaces position", fetch_log[3], 32'h400);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule